// File: doc/BRIEF.md
# Digit Entry Combination Lock

This block accepts a multi-digit code through four single-cycle strobes: raise, lower, step forward and step back. A one-hot focus pointer picks which digit the raise and lower strobes act on. Every digit is a small wrapping counter that moves only while it holds focus. The focus pointer goes empty after a stretch with no stepping strobes. A display driver can use the focus output to blink the selected digit.

A matcher compares all digits with a secret value fixed at build time. The unlock output rises only after the correct code has been present, unchanged, for a full hold period. Any difference drops unlock and restarts the wait.

All strobes are plain level inputs, sampled on each rising clock edge. They are expected to be already debounced and reduced to one-cycle pulses upstream. There is no data stream and therefore no valid/ready handshake. The clock rate is a parameter, so the idle timeout (default 5000 ms) and the hold time (default 1000 ms) can be scaled down for simulation.

Top module: `code_entry_lock`

## Requirements
- R1: After reset all digits are 0, the focus output is 0000 and unlock is low.
- R2: When focus is 0000, a step-forward or step-back strobe sets focus to 0001 (digit 0) on the next edge.
- R3: With focus non-empty, step-forward moves the set bit from position i to i+1, and from bit 3 back to bit 0. Step-back moves it from i to i-1, and from bit 0 to bit 3. Both strobes together leave focus unchanged.
- R4: Once IDLE_CYC consecutive edges pass with no stepping strobe after the last one (or after focus became non-empty), focus becomes 0000.
- R5: A digit changes only when its focus bit is set. While focus is 0000, no digit changes.
- R6: A raise strobe adds 1 to the focused digit and a lower strobe subtracts 1, both modulo 16 (15 raised gives 0, 0 lowered gives 15). Digit i occupies bits [4i+3:4i] of the digits output.
- R7: A raise and a lower strobe in the same cycle leave every digit unchanged.
- R8: Unlock rises on the HOLD_CYC-th edge after the edge that completed the matching code, provided the match holds throughout. Unlock then stays high while the match holds.
- R9: On the first edge where the digits differ from the secret, unlock falls. The next match must again last a full HOLD_CYC edges.
- R10: The focus output never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_pulse | input | 1 | Raise strobe for the focused digit |
| down_pulse | input | 1 | Lower strobe for the focused digit |
| next_pulse | input | 1 | Step focus forward |
| prev_pulse | input | 1 | Step focus back |
| digits_o | output | 16 | Current digits, digit i in bits [4i+3:4i] |
| focus_o | output | 4 | One-hot focus, 0000 when nothing is selected |
| unlock_o | output | 1 | High once the secret has been held long enough |

## Verification
The assertions check the following on every cycle:
- the one-hot shape of focus, the wake-up to digit 0 and the step-forward rotation;
- the idle clear at the end of the timeout;
- that unfocused or conflicting digits stay still and that a raise strobe wraps correctly;
- that a mismatch always clears unlock on the following edge.

Other behaviours are visible only in the bench's scenarios:
- the exact edge on which unlock first rises;
- that a broken and then restored match waits the whole hold time again;
- that the idle timeout begins counting at the last stepping strobe.

// File: rtl/comb_lock_pkg.sv
package comb_lock_pkg;

  // Converts a duration in milliseconds into a clock-cycle count, never less than 1.
  function automatic int unsigned ms_to_cycles(longint unsigned hz, longint unsigned ms);
    longint unsigned t;
    t = (hz * ms) / 1000;
    if (t == 0) t = 1;
    return t[31:0];
  endfunction

endpackage

// File: rtl/lock_focus_ring.sv
module lock_focus_ring #(
  parameter int unsigned N        = 4,
  parameter int unsigned IDLE_CYC = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         nxt,
  input  logic         prv,
  output logic [N-1:0] focus
);
  localparam int unsigned CW = $clog2(IDLE_CYC + 1);
  localparam logic [N-1:0] FIRST = {{(N-1){1'b0}}, 1'b1};

  logic [CW-1:0] idle_q;
  logic          nav;

  assign nav = nxt | prv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      focus  <= '0;
      idle_q <= '0;
    end else if (nav) begin
      idle_q <= '0;
      if (focus == '0)      focus <= FIRST;
      else if (nxt && !prv) focus <= {focus[N-2:0], focus[N-1]};
      else if (prv && !nxt) focus <= {focus[0], focus[N-1:1]};
    end else if (focus != '0) begin
      if (idle_q == CW'(IDLE_CYC - 1)) begin
        focus  <= '0;
        idle_q <= '0;
      end else begin
        idle_q <= idle_q + CW'(1);
      end
    end
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(focus));
  p_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (focus == '0 && nav) |=> focus == FIRST);
  p_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (focus != '0 && nxt && !prv) |=> focus == {$past(focus[N-2:0]), $past(focus[N-1])});
  p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (focus != '0 && !nav && idle_q == CW'(IDLE_CYC - 1)) |=> focus == '0);

endmodule

// File: rtl/lock_digit.sv
module lock_digit #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         up,
  input  logic         dn,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               value <= '0;
    else if (en && up && !dn) value <= value + W'(1);
    else if (en && dn && !up) value <= value - W'(1);
  end

  p_idle_digit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(value));
  p_conflict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |=> $stable(value));
  p_raise_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up && !dn) |=> value == W'($past(value) + W'(1)));

endmodule

// File: rtl/lock_match_hold.sv
module lock_match_hold #(
  parameter int unsigned NB       = 16,
  parameter logic [NB-1:0] SECRET = '0,
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] code,
  output logic          unlock
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] hold_q;
  logic          match;

  assign match = (code == SECRET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      unlock <= 1'b0;
    end else if (!match) begin
      hold_q <= '0;
      unlock <= 1'b0;
    end else if (hold_q == HW'(HOLD_CYC - 1)) begin
      unlock <= 1'b1;
    end else begin
      hold_q <= hold_q + HW'(1);
    end
  end

  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> !unlock);
  p_rise_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock) |-> ($past(match) && hold_q == HW'(HOLD_CYC - 1)));

endmodule

// File: rtl/code_entry_lock.sv
module code_entry_lock #(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned DIGIT_W    = 4,
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter int unsigned IDLE_MS    = 5000,
  parameter int unsigned HOLD_MS    = 1000,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] SECRET = 16'h3907
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          up_pulse,
  input  logic                          down_pulse,
  input  logic                          next_pulse,
  input  logic                          prev_pulse,
  output logic [NUM_DIGITS*DIGIT_W-1:0] digits_o,
  output logic [NUM_DIGITS-1:0]         focus_o,
  output logic                          unlock_o
);
  localparam int unsigned IDLE_CYC = comb_lock_pkg::ms_to_cycles(CLK_HZ, IDLE_MS);
  localparam int unsigned HOLD_CYC = comb_lock_pkg::ms_to_cycles(CLK_HZ, HOLD_MS);
  localparam int unsigned NB       = NUM_DIGITS * DIGIT_W;

  logic [NUM_DIGITS-1:0] focus;
  logic [NB-1:0]         code;

  lock_focus_ring #(.N(NUM_DIGITS), .IDLE_CYC(IDLE_CYC)) u_focus (
    .clk(clk), .rst_n(rst_n), .nxt(next_pulse), .prv(prev_pulse), .focus(focus)
  );

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    lock_digit #(.W(DIGIT_W)) u_digit (
      .clk(clk), .rst_n(rst_n), .en(focus[i]), .up(up_pulse), .dn(down_pulse),
      .value(code[i*DIGIT_W +: DIGIT_W])
    );
  end

  lock_match_hold #(.NB(NB), .SECRET(SECRET), .HOLD_CYC(HOLD_CYC)) u_match (
    .clk(clk), .rst_n(rst_n), .code(code), .unlock(unlock_o)
  );

  assign digits_o = code;
  assign focus_o  = focus;

  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> (!unlock_o && focus_o == '0));

endmodule

// File: tb/sim_code_entry_lock.sv
module sim_code_entry_lock;
  localparam time CLK_PERIOD = 10ns;
  localparam longint unsigned HZ = 1000;
  localparam int IDLE_MS = 50;
  localparam int HOLD_MS = 20;
  localparam int IDLE = 50;   // HZ*IDLE_MS/1000
  localparam int HOLD = 20;   // HZ*HOLD_MS/1000
  localparam logic [15:0] SECRET = 16'h3907;

  logic clk = 0, rst_n = 0;
  logic up = 0, dn = 0, nx = 0, pv = 0;
  logic [15:0] digits;
  logic [3:0]  focus;
  logic        unlock;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_code;
  logic [3:0]  m_focus;
  int          m_idle, m_hold;
  logic        m_unlock;

  always #(CLK_PERIOD/2) clk = ~clk;

  code_entry_lock #(.CLK_HZ(HZ), .IDLE_MS(IDLE_MS), .HOLD_MS(HOLD_MS), .SECRET(SECRET)) u0 (
    .clk(clk), .rst_n(rst_n), .up_pulse(up), .down_pulse(dn), .next_pulse(nx),
    .prev_pulse(pv), .digits_o(digits), .focus_o(focus), .unlock_o(unlock)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nib_step(logic [3:0] v, bit inc);
    return inc ? v + 4'd1 : v - 4'd1;
  endfunction

  task automatic model_edge(bit u, bit d, bit n, bit p);
    bit mt;
    mt = (m_code == SECRET);
    if (!mt) begin m_hold = 0; m_unlock = 0; end
    else if (m_hold == HOLD - 1) m_unlock = 1;
    else m_hold++;
    for (int i = 0; i < 4; i++)
      if (m_focus[i] && (u ^ d)) m_code[4*i +: 4] = nib_step(m_code[4*i +: 4], u);
    if (n || p) begin
      m_idle = 0;
      if (m_focus == 0) m_focus = 4'b0001;
      else if (n && !p) m_focus = {m_focus[2:0], m_focus[3]};
      else if (p && !n) m_focus = {m_focus[0], m_focus[3:1]};
    end else if (m_focus != 0) begin
      if (m_idle == IDLE - 1) begin m_focus = 0; m_idle = 0; end
      else m_idle++;
    end
  endtask

  // Called at a negedge: drive, take one edge, compare at the following negedge.
  task automatic step(bit u, bit d, bit n, bit p);
    up = u; dn = d; nx = n; pv = p;
    @(posedge clk);
    model_edge(u, d, n, p);
    @(negedge clk);
    up = 0; dn = 0; nx = 0; pv = 0;
    chk(focus == m_focus, "R3 focus model", 32'(focus), 32'(m_focus));
    chk(digits == m_code, "R6 digits model", 32'(digits), 32'(m_code));
    chk(unlock == m_unlock, "R8 unlock model", 32'(unlock), 32'(m_unlock));
    chk($countones(focus) <= 1, "R10 one-hot", 32'(focus), 32'(m_focus));
  endtask

  task automatic idle_n(int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0);
  endtask

  task automatic raise_n(int k);
    for (int i = 0; i < k; i++) step(1, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    m_code = 0; m_focus = 0; m_idle = 0; m_hold = 0; m_unlock = 0;
    repeat (3) @(negedge clk);
    chk(digits == 0 && focus == 0 && unlock == 0, "R1 reset", {digits, focus, 3'b0, unlock}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(digits == 0 && focus == 0 && unlock == 0, "R1 after release", {digits, focus, 3'b0, unlock}, 0);

    step(1, 0, 0, 0);
    chk(digits == 16'h0000, "R5 no focus no change", 32'(digits), 0);
    step(0, 0, 0, 1);
    chk(focus == 4'b0001, "R2 wake on prev", 32'(focus), 1);
    step(0, 0, 0, 1);
    chk(focus == 4'b1000, "R3 prev wrap", 32'(focus), 8);
    step(0, 0, 1, 0);
    chk(focus == 4'b0001, "R3 next wrap", 32'(focus), 1);
    step(0, 0, 1, 1);
    chk(focus == 4'b0001, "R3 both steps hold", 32'(focus), 1);
    step(0, 1, 0, 0);
    chk(digits[3:0] == 4'hF, "R6 lower wraps", 32'(digits[3:0]), 15);
    step(1, 0, 0, 0);
    chk(digits[3:0] == 4'h0, "R6 raise wraps", 32'(digits[3:0]), 0);
    step(1, 1, 0, 0);
    chk(digits == 16'h0000, "R7 raise+lower ignored", 32'(digits), 0);

    step(0, 0, 1, 0);
    idle_n(IDLE - 1);
    chk(focus == 4'b0010, "R4 focus kept before timeout", 32'(focus), 2);
    idle_n(1);
    chk(focus == 4'b0000, "R4 focus cleared at timeout", 32'(focus), 0);
    step(1, 0, 0, 0);
    chk(digits == 16'h0000, "R5 cleared focus blocks raise", 32'(digits), 0);

    step(0, 0, 1, 0);
    raise_n(7);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    raise_n(9);
    step(0, 0, 1, 0);
    raise_n(3);
    chk(digits == SECRET, "R8 code entered", 32'(digits), 32'(SECRET));
    idle_n(HOLD - 1);
    chk(unlock == 0, "R8 not yet unlocked", 32'(unlock), 0);
    idle_n(1);
    chk(unlock == 1, "R8 unlocked after hold", 32'(unlock), 1);
    idle_n(3);
    chk(unlock == 1, "R8 stays unlocked", 32'(unlock), 1);
    step(1, 0, 0, 0);
    idle_n(1);
    chk(unlock == 0, "R9 drop on mismatch", 32'(unlock), 0);
    step(0, 1, 0, 0);
    idle_n(HOLD - 1);
    chk(unlock == 0, "R9 hold restarted", 32'(unlock), 0);
    idle_n(1);
    chk(unlock == 1, "R9 unlock after fresh hold", 32'(unlock), 1);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 9) == 0, ($urandom % 11) == 0);
      if (($urandom % 200) == 0) idle_n(IDLE);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule